// File: doc/BRIEF.md
# GF(4096) Tower-Field Multiplier

This block multiplies two elements of the 4096-element binary field. Elements are not held in the usual single-polynomial basis. They use a two-level tower. Each 12-bit word is a pair of 6-bit digits. Each digit is an element of the 64-element field, reduced by x^6+x+1. The pair is a degree-one polynomial over that small field, taken modulo the quadratic X^2+X+c, where c is 0x21, the inverse of the small field's generator. Error-correction datapaths that work in this representation use the block for syndrome and locator arithmetic.

Each accepted operand pair gives one product one clock later. A valid flag travels alongside the product. A second operating mode applies the primitive-element step instead of a general product. In that mode the first operand is multiplied by the fixed element 0xE01, and the zero element maps to one. The output register keeps its contents until the next accepted input. The asynchronous active-low reset is released synchronously inside the block.

Top module: `gf4k_tower_mul`

## Requirements
- R1: While reset is asserted, and on the first cycles after its release, out_valid is 0 and out_prod is 0x000.
- R2: The 6-bit digit arithmetic reduces by x^6+x+1. For example, 0x020 times 0x002 gives 0x003.
- R3: The high digit is in bits 11:6 and the low digit is in bits 5:0. The extension constant is 0x21. Squaring 0x040 gives 0x061.
- R4: In multiply mode (in_step = 0), the high digit of the product is m(ah^al, bh^bl) ^ m(al, bl). The low digit is m(m(ah, bh), 0x21) ^ m(al, bl). Here m is the 6-bit field product.
- R5: In multiply mode, if either operand is 0x000, the product is 0x000.
- R6: In multiply mode, 0x001 is the identity: a times 0x001 returns a.
- R7: In step mode (in_step = 1), an input in_a of 0x000 gives 0x001.
- R8: In step mode, a nonzero in_a gives in_a times 0xE01, and in_b has no effect. For example, in_a = 0x001 gives 0xE01.
- R9: The product and out_valid appear exactly one clock after the cycle in which in_valid is sampled high. out_valid is low one clock after in_valid is sampled low.
- R10: When in_valid is low, out_prod holds its previous value.
- R11: Multiplication is commutative: a times b equals b times a.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operands are valid this cycle |
| in_step | input | 1 | 1 selects the primitive-element step on in_a, 0 selects a general multiply |
| in_a | input | 12 | First operand, high digit in bits 11:6 |
| in_b | input | 12 | Second operand; unused in step mode |
| out_valid | output | 1 | Product valid, one cycle after in_valid |
| out_prod | output | 12 | Registered product |

## Verification
The only state in the block is the product and valid register, plus the reset synchronizer. A wrong next-state value therefore shows on out_prod on the very next clock after the operands are accepted. A bad hold enable shows as a changed out_prod on an idle cycle. A defect in the digit multiplier, the reduction constant or the extension constant corrupts specific bit patterns. These errors are caught by directed corner cases (zero, identity, the reduction wrap, squaring the pure high digit) and by a long run of random operands. The random run is compared each cycle against a behavioural model that reduces a full carry-less product.

// File: rtl/gf4k_pkg.sv
package gf4k_pkg;
  localparam int unsigned DIGIT_W   = 6;
  localparam int unsigned ELEM_W    = 2 * DIGIT_W;
  // x^6 + x + 1 with the x^6 term dropped: the value folded back on overflow
  localparam logic [DIGIT_W-1:0] DIGIT_POLY = 6'h03;
  // inverse of the small-field generator, constant term of the quadratic
  localparam logic [DIGIT_W-1:0] EXT_CONST  = 6'h21;
  // multiplier used by the primitive-element step
  localparam logic [ELEM_W-1:0]  STEP_CONST = 12'hE01;
  localparam logic [ELEM_W-1:0]  ELEM_ONE   = 12'h001;
  localparam int unsigned NUM_PAR_MUL = 3;
endpackage

// File: rtl/gf64_mul.sv
module gf64_mul #(
  parameter int unsigned W = 6,
  parameter logic [W-1:0] POLY = 6'h03
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] p
);
  logic [W-1:0] acc;
  logic [W-1:0] xs;
  logic [W-1:0] ys;

  always_comb begin
    acc = '0;
    xs  = x;
    ys  = y;
    for (int i = 0; i < int'(W); i++) begin
      if (xs[0]) acc = acc ^ ys;
      xs = xs >> 1;
      ys = {ys[W-2:0], 1'b0} ^ (ys[W-1] ? POLY : '0);
    end
    p = acc;
  end
endmodule

// File: rtl/gf4k_mul_core.sv
module gf4k_mul_core
  import gf4k_pkg::*;
(
  input  logic [ELEM_W-1:0] a,
  input  logic [ELEM_W-1:0] b,
  output logic [ELEM_W-1:0] p
);
  logic [DIGIT_W-1:0] a_hi, a_lo, b_hi, b_lo;
  logic [DIGIT_W-1:0] opx [NUM_PAR_MUL];
  logic [DIGIT_W-1:0] opy [NUM_PAR_MUL];
  logic [DIGIT_W-1:0] prd [NUM_PAR_MUL];
  logic [DIGIT_W-1:0] hh_scaled;
  logic [DIGIT_W-1:0] hi_d, lo_d;

  assign a_hi = a[ELEM_W-1:DIGIT_W];
  assign a_lo = a[DIGIT_W-1:0];
  assign b_hi = b[ELEM_W-1:DIGIT_W];
  assign b_lo = b[DIGIT_W-1:0];

  // slot 0: cross sums, slot 1: low digits, slot 2: high digits
  assign opx[0] = a_hi ^ a_lo;
  assign opy[0] = b_hi ^ b_lo;
  assign opx[1] = a_lo;
  assign opy[1] = b_lo;
  assign opx[2] = a_hi;
  assign opy[2] = b_hi;

  for (genvar g = 0; g < NUM_PAR_MUL; g++) begin : g_dmul
    gf64_mul #(.W(DIGIT_W), .POLY(DIGIT_POLY)) i_dmul (
      .x(opx[g]),
      .y(opy[g]),
      .p(prd[g])
    );
  end

  gf64_mul #(.W(DIGIT_W), .POLY(DIGIT_POLY)) i_scale (
    .x(prd[2]),
    .y(EXT_CONST),
    .p(hh_scaled)
  );

  assign hi_d = prd[0] ^ prd[1];
  assign lo_d = hh_scaled ^ prd[1];
  assign p    = {hi_d, lo_d};
endmodule

// File: rtl/gf4k_tower_mul.sv
module gf4k_tower_mul
  import gf4k_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_step,
  input  logic [ELEM_W-1:0] in_a,
  input  logic [ELEM_W-1:0] in_b,
  output logic              out_valid,
  output logic [ELEM_W-1:0] out_prod
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // operand selection and result
  logic [ELEM_W-1:0] core_b;
  logic [ELEM_W-1:0] core_p;
  logic              step_zero;
  logic [ELEM_W-1:0] res_nxt;

  assign core_b    = in_step ? STEP_CONST : in_b;
  assign step_zero = in_step && (in_a == '0);

  gf4k_mul_core i_core (
    .a(in_a),
    .b(core_b),
    .p(core_p)
  );

  assign res_nxt = step_zero ? ELEM_ONE : core_p;

  if (REG_OUT) begin : g_reg
    logic [ELEM_W-1:0] prod_q, prod_d;
    logic              vld_q, vld_d;
    logic              prod_en;

    assign prod_en = in_valid;

    always_comb begin
      prod_d = prod_q;
      if (prod_en) prod_d = res_nxt;
      vld_d = in_valid;
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        prod_q <= '0;
        vld_q  <= 1'b0;
      end else begin
        prod_q <= prod_d;
        vld_q  <= vld_d;
      end
    end

    assign out_prod  = prod_q;
    assign out_valid = vld_q;
  end else begin : g_comb
    assign out_prod  = res_nxt;
    assign out_valid = in_valid;
  end
endmodule

// File: rtl/gf4k_tower_mul_chk.sv
module gf4k_tower_mul_chk
  import gf4k_pkg::*;
(
  input logic              clk,
  input logic              rst_sync_n,
  input logic              in_valid,
  input logic              in_step,
  input logic [ELEM_W-1:0] in_a,
  input logic [ELEM_W-1:0] in_b,
  input logic              out_valid,
  input logic [ELEM_W-1:0] out_prod
);
  // the properties describe the registered build (REG_OUT = 1)
  p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);
  p_valid_drops_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> $stable(out_prod));
  p_zero_operand_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !in_step && (in_a == '0 || in_b == '0)) |=> (out_prod == '0));
  p_identity_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !in_step && in_b == 12'h001) |=> (out_prod == $past(in_a)));
  p_step_zero_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_step && in_a == '0) |=> (out_prod == 12'h001));
  p_step_one_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_step && in_a == 12'h001) |=> (out_prod == 12'hE01));
endmodule

bind gf4k_tower_mul gf4k_tower_mul_chk i_chk (
  .clk(clk),
  .rst_sync_n(rst_sync_n),
  .in_valid(in_valid),
  .in_step(in_step),
  .in_a(in_a),
  .in_b(in_b),
  .out_valid(out_valid),
  .out_prod(out_prod)
);

// File: tb/test_gf4k_tower_mul.sv
`timescale 1ns/1ps
module test_gf4k_tower_mul;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_step;
  logic [11:0] in_a;
  logic [11:0] in_b;
  logic        out_valid;
  logic [11:0] out_prod;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference state
  logic [11:0] mdl_prod;
  logic        mdl_valid;

  gf4k_tower_mul i_gf4k_tower_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_step(in_step),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_prod(out_prod)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // small-field product: full carry-less product, then polynomial division
  function automatic int ref_m64(input int x, input int y);
    int full = 0;
    for (int i = 0; i < 6; i++)
      if ((x >> i) & 1) full = full ^ (y << i);
    for (int d = 10; d >= 6; d--)
      if ((full >> d) & 1) full = full ^ (32'h43 << (d - 6));
    return full & 63;
  endfunction

  function automatic int ref_mul(input int a, input int b);
    int ah = (a >> 6) & 63;
    int al = a & 63;
    int bh = (b >> 6) & 63;
    int bl = b & 63;
    int lo_prod = ref_m64(al, bl);
    int hi = ref_m64(ah ^ al, bh ^ bl) ^ lo_prod;
    int lo = ref_m64(ref_m64(ah, bh), 33) ^ lo_prod;
    return (hi << 6) | lo;
  endfunction

  function automatic int ref_res(input bit s, input int a, input int b);
    if (s) return (a == 0) ? 1 : ref_mul(a, 12'hE01);
    return ref_mul(a, b);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%03h expected=0x%03h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, clock, compare at the following negedge
  task automatic cyc(input string req, input bit v, input bit s,
                     input logic [11:0] a, input logic [11:0] b);
    in_valid = v; in_step = s; in_a = a; in_b = b;
    @(posedge clk);
    if (v) mdl_prod = 12'(ref_res(s, int'(a), int'(b)));
    mdl_valid = v;
    @(negedge clk);
    chk({req, " valid"}, int'(out_valid), int'(mdl_valid));
    chk(req, int'(out_prod), int'(mdl_prod));
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] ab;
    rst_n = 1'b0; in_valid = 1'b0; in_step = 1'b0; in_a = '0; in_b = '0;
    mdl_prod = '0; mdl_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(out_valid), 0);
    chk("R1 reset prod", int'(out_prod), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 release prod", int'(out_prod), 0);
    repeat (4) @(negedge clk);

    // R2 reduction wrap
    cyc("R2", 1, 0, 12'h020, 12'h002);
    chk("R2 literal", int'(out_prod), 12'h003);
    // R3 layout and extension constant
    cyc("R3", 1, 0, 12'h040, 12'h040);
    chk("R3 literal", int'(out_prod), 12'h061);
    // R5 zero operands
    cyc("R5", 1, 0, 12'h000, 12'h5A3);
    chk("R5 literal a", int'(out_prod), 0);
    cyc("R5", 1, 0, 12'hFFF, 12'h000);
    chk("R5 literal b", int'(out_prod), 0);
    // R6 identity
    cyc("R6", 1, 0, 12'hABC, 12'h001);
    chk("R6 literal", int'(out_prod), 12'hABC);
    cyc("R6", 1, 0, 12'h001, 12'h7E5);
    chk("R6 literal swap", int'(out_prod), 12'h7E5);
    // R7 step on zero
    cyc("R7", 1, 1, 12'h000, 12'h123);
    chk("R7 literal", int'(out_prod), 12'h001);
    // R8 step on one, b ignored
    cyc("R8", 1, 1, 12'h001, 12'hFFF);
    chk("R8 literal", int'(out_prod), 12'hE01);
    cyc("R8", 1, 1, 12'h3C7, 12'h000);
    ab = out_prod;
    cyc("R8", 1, 1, 12'h3C7, 12'h9A9);
    chk("R8 b ignored", int'(out_prod), int'(ab));
    // R10 hold while idle, R9 valid drop
    cyc("R10", 0, 0, 12'h111, 12'h222);
    chk("R10 literal hold", int'(out_prod), int'(ab));
    cyc("R9", 0, 1, 12'h000, 12'h000);
    chk("R9 idle valid", int'(out_valid), 0);
    // R11 commutativity
    cyc("R11", 1, 0, 12'h9D2, 12'h4B7);
    ab = out_prod;
    cyc("R11", 1, 0, 12'h4B7, 12'h9D2);
    chk("R11 swap", int'(out_prod), int'(ab));
    // R4 random operands with random gaps, checked every cycle
    for (int n = 0; n < 2000; n++) begin
      cyc("R4", 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 7) == 0),
          12'($urandom), 12'($urandom));
    end
    // R4 all-ones corner
    cyc("R4", 1, 0, 12'hFFF, 12'hFFF);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule